// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every data element of one read or write burst in a double-data-rate memory device. A mode load command programs the burst length (2, 4 or 8), the ordering (sequential or interleaved) and the read latency. A burst start strobe then supplies the starting column. Each advance strobe steps to the next element. All addresses stay inside the aligned block whose size equals the burst length, and they wrap at its edge.

The mode word is 15 bits wide. Bits 14..13 select the register: both must be 0 for this block to accept the load, and any other value addresses a different register, which this block ignores. A load with a reserved field raises a one-cycle error pulse and leaves the settings unchanged. A valid load with the DLL-reset bit set raises a one-cycle DLL-reset pulse. The read latency is only captured and shown on an output. The same length and ordering serve both read and write bursts.

Top module: `burst_col_seq`

## Requirements
- R1: After a synchronous active-high reset, `col_valid`, `col_last`, `mode_err` and `dll_rst` are 0. A following burst runs with length 2 in sequential order, and `lat_2p5` is 0.
- R2: A `mode_load` whose `mode_word[14:13]` is not 2'b00 changes no setting and raises neither `mode_err` nor `dll_rst`.
- R3: `mode_word[2:0]` selects the burst length: 3'b001 gives 2 elements, 3'b010 gives 4 and 3'b011 gives 8. All other codes are reserved.
- R4: `mode_word[3]` selects the ordering: 0 is sequential and 1 is interleaved. It applies to every burst started after the load.
- R5: Within a burst, the column bits above the low log2(length) bits stay equal to those of `start_col`.
- R6: In sequential order, element k has low offset (start + k) mod length. For example, length 4 with start 1 gives 1,2,3,0.
- R7: In interleaved order, element k has low offset start XOR k. For example, length 8 with start 5 gives 5,4,7,6,1,0,3,2.
- R8: `col_last` is 1 exactly while the final element of the programmed length is shown. An advance on that element drops `col_valid` in the next cycle.
- R9: A base-register load is reserved, and raises `mode_err` for one cycle while keeping the previous settings, if any of these holds: the length code is not 001, 010 or 011; the latency code `mode_word[6:4]` is neither 3'b010 nor 3'b110; or `mode_word[12:7]` is neither 0 nor 6'b000010.
- R10: A valid base-register load with `mode_word[8]` set raises `dll_rst` for exactly one cycle, in the cycle after the load.
- R11: `lat_2p5` shows the last valid latency code: 0 for 3'b010 (latency 2) and 1 for 3'b110 (latency 2.5).
- R12: In the cycle after `burst_start`, `col_valid` is 1 and `col_addr` equals `start_col`, even if a burst was already running. The address holds while `advance` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_load | input | 1 | Mode register load strobe |
| mode_word | input | 15 | Mode word: select bits 14..13, op field 12..7, latency 6..4, ordering 3, length 2..0 |
| burst_start | input | 1 | Start a burst at `start_col` |
| start_col | input | COL_W | Starting column address |
| advance | input | 1 | Step to the next element |
| col_addr | output | COL_W | Current column address |
| col_valid | output | 1 | A burst element is being shown |
| col_last | output | 1 | Current element is the final one |
| mode_err | output | 1 | One-cycle pulse: reserved mode load rejected |
| dll_rst | output | 1 | One-cycle pulse: DLL reset requested |
| lat_2p5 | output | 1 | Captured latency is 2.5 |

## Verification
The checker watches several rules on every cycle:
- A restart always presents the starting column.
- The address holds while no advance arrives.
- The upper column bits never move inside a burst.
- An advance on the last element ends the burst.
- The error and DLL pulses only ever follow a base-register load, and never appear together.

The element orderings for each length and type, the rejection of reserved codes with the old settings kept, the silence toward other-register loads, and the latency capture depend on the programmed history. Only the bench's directed scenarios can show these.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int MODE_W = 15;
  localparam int OFF_W  = 3;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_INTL = 1'b1} order_t;

  localparam logic [2:0] LEN2 = 3'b001;
  localparam logic [2:0] LEN4 = 3'b010;
  localparam logic [2:0] LEN8 = 3'b011;
  localparam logic [2:0] LAT20 = 3'b010;
  localparam logic [2:0] LAT25 = 3'b110;
  localparam logic [5:0] OP_NORM = 6'b000000;
  localparam logic [5:0] OP_DLL  = 6'b000010;

  function automatic logic [OFF_W-1:0] len_mask(input logic [2:0] code);
    case (code)
      LEN4:    len_mask = 3'b011;
      LEN8:    len_mask = 3'b111;
      default: len_mask = 3'b001;
    endcase
  endfunction

  function automatic logic len_ok(input logic [2:0] code);
    len_ok = (code == LEN2) || (code == LEN4) || (code == LEN8);
  endfunction
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output logic [2:0]        len_code,
  output order_t            order,
  output logic              lat_2p5,
  output logic              err,
  output logic              dll
);
  logic       base_sel;
  logic       fields_ok;
  logic [5:0] op_f;
  logic [2:0] lat_f;

  assign base_sel  = (word[14:13] == 2'b00);
  assign op_f      = word[12:7];
  assign lat_f     = word[6:4];
  assign fields_ok = len_ok(word[2:0])
                   && ((lat_f == LAT20) || (lat_f == LAT25))
                   && ((op_f == OP_NORM) || (op_f == OP_DLL));

  always_ff @(posedge clk) begin
    if (rst) begin
      len_code <= LEN2;
      order    <= ORD_SEQ;
      lat_2p5  <= 1'b0;
      err      <= 1'b0;
      dll      <= 1'b0;
    end else begin
      err <= 1'b0;
      dll <= 1'b0;
      if (load && base_sel) begin
        if (fields_ok) begin
          len_code <= word[2:0];
          order    <= order_t'(word[3]);
          lat_2p5  <= (lat_f == LAT25);
          dll      <= word[8];
        end else begin
          err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             advance,
  input  logic [2:0]       len_code,
  input  order_t           order,
  output logic [COL_W-1:0] col_addr,
  output logic             valid,
  output logic             last
);
  localparam int HI_W = COL_W - OFF_W;

  logic [COL_W-1:0] base_q;
  logic [OFF_W-1:0] off_q, k_q, mask_q, k_inc;
  order_t           ord_q;
  logic [OFF_W-1:0] sel_off;
  logic [COL_W-1:0] mask_ext;

  assign k_inc = k_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      off_q  <= '0;
      k_q    <= '0;
      mask_q <= 3'b001;
      ord_q  <= ORD_SEQ;
      valid  <= 1'b0;
      last   <= 1'b0;
    end else if (start) begin
      base_q <= start_col;
      off_q  <= start_col[OFF_W-1:0];
      k_q    <= '0;
      mask_q <= len_mask(len_code);
      ord_q  <= order;
      valid  <= 1'b1;
      last   <= 1'b0;
    end else if (advance && valid) begin
      if (last) begin
        valid <= 1'b0;
        last  <= 1'b0;
      end else begin
        k_q  <= k_inc;
        last <= (k_inc == mask_q);
      end
    end
  end

  // ordering variant: modular add or bitwise XOR on the low offset
  always_comb begin
    if (ord_q == ORD_INTL) sel_off = off_q ^ k_q;
    else                   sel_off = off_q + k_q;
  end

  assign mask_ext = {{HI_W{1'b0}}, mask_q};
  assign col_addr = (base_q & ~mask_ext)
                  | ({{HI_W{1'b0}}, sel_off} & mask_ext);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_load,
  input  logic [14:0]      mode_word,
  input  logic             burst_start,
  input  logic [COL_W-1:0] start_col,
  input  logic             advance,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             col_last,
  output logic             mode_err,
  output logic             dll_rst,
  output logic             lat_2p5
);
  logic [2:0] len_code;
  order_t     order;

  bcs_mode_reg u_mode (
    .clk(clk), .rst(rst), .load(mode_load), .word(mode_word),
    .len_code(len_code), .order(order), .lat_2p5(lat_2p5),
    .err(mode_err), .dll(dll_rst)
  );

  bcs_col_gen #(.COL_W(COL_W)) u_gen (
    .clk(clk), .rst(rst), .start(burst_start), .start_col(start_col),
    .advance(advance), .len_code(len_code), .order(order),
    .col_addr(col_addr), .valid(col_valid), .last(col_last)
  );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_load,
  input logic [14:0]      mode_word,
  input logic             burst_start,
  input logic [COL_W-1:0] start_col,
  input logic             advance,
  input logic [COL_W-1:0] col_addr,
  input logic             col_valid,
  input logic             col_last,
  input logic             mode_err,
  input logic             dll_rst
);
  assert_restart_R12: assert property (@(posedge clk) disable iff (rst)
    burst_start |=> (col_valid && col_addr == $past(start_col)));

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !advance && !burst_start) |=> $stable(col_addr));

  assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !burst_start) |=> (!col_valid || col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3])));

  assert_end_R8: assert property (@(posedge clk) disable iff (rst)
    (col_valid && col_last && advance && !burst_start) |=> !col_valid);

  assert_last_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  assert_pulse_src_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_err || dll_rst) |-> $past(mode_load && mode_word[14:13] == 2'b00));

  assert_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mode_err, dll_rst}));

  assert_dll_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    dll_rst |-> $past(mode_word[8]));
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst(rst), .mode_load(mode_load), .mode_word(mode_word),
  .burst_start(burst_start), .start_col(start_col), .advance(advance),
  .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last),
  .mode_err(mode_err), .dll_rst(dll_rst)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_load = 1'b0;
  logic [14:0] mode_word = '0;
  logic burst_start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic advance = 1'b0;
  logic [COL_W-1:0] col_addr;
  logic col_valid, col_last, mode_err, dll_rst, lat_2p5;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_word(mode_word),
    .burst_start(burst_start), .start_col(start_col), .advance(advance),
    .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last),
    .mode_err(mode_err), .dll_rst(dll_rst), .lat_2p5(lat_2p5)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] mk(input logic [1:0] sel, input logic [5:0] op,
                                     input logic [2:0] lat, input logic ord, input logic [2:0] len);
    mk = {sel, op, lat, ord, len};
  endfunction

  // drive a load; sample pulses in the following cycle
  task automatic load_mode(input logic [14:0] w, input logic exp_err, input logic exp_dll, input string req);
    @(negedge clk);
    mode_load = 1'b1; mode_word = w;
    @(negedge clk);
    mode_load = 1'b0;
    chk({req, " err"}, 32'(mode_err), 32'(exp_err));
    chk({req, " dll"}, 32'(dll_rst), 32'(exp_dll));
    @(negedge clk);
    chk({req, " pulse clear"}, 32'({mode_err, dll_rst}), 32'd0);
  endtask

  // run a whole burst with advance held high and compare each element
  task automatic run_burst(input logic [COL_W-1:0] s, input int len, input logic intl, input string req);
    logic [COL_W-1:0] m = COL_W'(len - 1);
    @(negedge clk);
    burst_start = 1'b1; start_col = s;
    @(negedge clk);
    burst_start = 1'b0;
    advance = 1'b1;
    for (int k = 0; k < len; k++) begin
      logic [COL_W-1:0] off = intl ? (s ^ COL_W'(k)) : (s + COL_W'(k));
      logic [COL_W-1:0] exp_a = (s & ~m) | (off & m);
      chk({req, " addr"}, 32'(col_addr), 32'(exp_a));
      chk({req, " valid/last"}, 32'({col_valid, col_last}), 32'({1'b1, k == len - 1}));
      @(negedge clk);
    end
    advance = 1'b0;
    chk({req, " ends"}, 32'(col_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 reset outs", 32'({col_valid, col_last, mode_err, dll_rst, lat_2p5}), 32'd0);
    run_burst(10'h2A5, 2, 1'b0, "R1 default len2 seq");
  endtask

  task automatic t_seq();
    load_mode(mk(2'b00, 6'd0, 3'b010, 1'b0, 3'b010), 1'b0, 1'b0, "R3 load len4");
    run_burst(10'h1C1, 4, 1'b0, "R6 seq len4 start1");
    load_mode(mk(2'b00, 6'd0, 3'b010, 1'b0, 3'b011), 1'b0, 1'b0, "R3 load len8");
    run_burst(10'h3F6, 8, 1'b0, "R6 R5 seq len8 start6");
  endtask

  task automatic t_intl();
    load_mode(mk(2'b00, 6'd0, 3'b110, 1'b1, 3'b011), 1'b0, 1'b0, "R4 load intl8");
    chk("R11 lat 2.5", 32'(lat_2p5), 32'd1);
    run_burst(10'h0AD, 8, 1'b1, "R7 intl len8 start5");
    load_mode(mk(2'b00, 6'd0, 3'b010, 1'b1, 3'b010), 1'b0, 1'b0, "R4 load intl4");
    chk("R11 lat 2", 32'(lat_2p5), 32'd0);
    run_burst(10'h147, 4, 1'b1, "R7 intl len4 start3");
  endtask

  task automatic t_reserved();
    load_mode(mk(2'b00, 6'd0, 3'b010, 1'b0, 3'b100), 1'b1, 1'b0, "R9 bad len");
    load_mode(mk(2'b00, 6'd0, 3'b011, 1'b0, 3'b011), 1'b1, 1'b0, "R9 bad lat");
    load_mode(mk(2'b00, 6'b000100, 3'b010, 1'b0, 3'b011), 1'b1, 1'b0, "R9 bad op");
    run_burst(10'h147, 4, 1'b1, "R9 settings kept");
  endtask

  task automatic t_other_reg();
    load_mode(mk(2'b01, 6'd0, 3'b110, 1'b0, 3'b011), 1'b0, 1'b0, "R2 other reg");
    load_mode(mk(2'b10, 6'b111111, 3'b111, 1'b0, 3'b111), 1'b0, 1'b0, "R2 other reg bad");
    chk("R2 lat kept", 32'(lat_2p5), 32'd0);
    run_burst(10'h2B2, 4, 1'b1, "R2 settings kept");
  endtask

  task automatic t_dll();
    load_mode(mk(2'b00, 6'b000010, 3'b010, 1'b0, 3'b001), 1'b0, 1'b1, "R10 dll load");
    run_burst(10'h003, 2, 1'b0, "R10 R3 len2 after dll");
  endtask

  task automatic t_restart_hold();
    load_mode(mk(2'b00, 6'd0, 3'b010, 1'b0, 3'b011), 1'b0, 1'b0, "R12 load len8");
    @(negedge clk);
    burst_start = 1'b1; start_col = 10'h102;
    @(negedge clk);
    burst_start = 1'b0; advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    chk("R12 step", 32'(col_addr), 32'h103);
    @(negedge clk);
    @(negedge clk);
    chk("R12 hold", 32'({col_valid, col_addr}), 32'({1'b1, 10'h103}));
    burst_start = 1'b1; start_col = 10'h3FE;
    @(negedge clk);
    burst_start = 1'b0;
    chk("R12 restart", 32'({col_valid, col_last, col_addr}), 32'({1'b1, 1'b0, 10'h3FE}));
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    chk("R5 R6 wrap", 32'(col_addr), 32'h3FF);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_seq();
    t_intl();
    t_reserved();
    t_other_reg();
    t_dll();
    t_restart_hold();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule